// File: doc/BRIEF.md
# Speed-Mode PHY Function Configurator

This block sits between a host controller's mode-switch logic and the control words of a storage-card PHY. Each time the bus is moved to a new timing mode, clock or bus width, the requester offers one mode request on a valid/ready handshake. The request carries the timing-mode code, an SDIO-card flag, a slow-mode preference and a flag that says the card clock runs above 52 MHz. The block then updates the PHY control words one step at a time. It sets the SDIO-mode and slow-mode bits of the timing word. Unless slow mode is chosen, it turns off the card clock, rewrites the DDR and async fields of the function word, and turns the clock back on. At the end it starts the PHY initialisation and waits until the PHY reports that it has finished.

Every result is a register output. The function word and the timing word keep their bit positions, because the PHY decodes those fields. A request with the same clock code, bus width and timing mode as the last request that was carried out is accepted and finishes at once. It does not rewrite anything and does not start an init.

Top module: `phy_speed_cfg`

## Requirements
- R1: After reset, req_ready=1, card_clk_en=1, init_start=0, phy_func_ctrl=32'h0000_0010 (only the async bit 4 set) and phy_timing_adj=0.
- R2: For timing code 10 (DDR with strobe), the function word gets DQ DDR bits [15:8] all set, command DDR bit 16 set and async bit 4 cleared (value 32'h0001_FF00).
- R3: For timing codes 7 and 8 (50/52 MHz DDR), the function word gets bits [15:8], bit 16 and bit 4 all set (32'h0001_FF10).
- R4: For every other non-legacy code whose request does not select slow mode, the function word gets bits [15:8] and bit 16 cleared and bit 4 set (32'h0000_0010).
- R5: The function word changes only while card_clk_en is low. card_clk_en falls before that write and rises again after it, before the init starts.
- R6: When req_hi_freq=1, slow-mode bit 29 of the timing word is cleared whatever the other request inputs are.
- R7: For timing codes 1, 2, 3 and 4 (low-speed and high-speed SDR) with req_hi_freq=0, bit 29 is set to req_sdio OR req_slow_pref. For codes 5 to 10, bit 29 is cleared.
- R8: For timing code 0 (legacy), bit 29 becomes req_slow_pref AND NOT req_hi_freq. Bit 28 and the function word keep their values, the card clock is not gated, and an init is started.
- R9: When slow mode ends up set on a non-legacy request, the function word is not written and the clock is not gated, but the init still starts.
- R10: On non-legacy requests, SDIO-mode bit 28 of the timing word takes the value of req_sdio.
- R11: A request whose clock code, bus width and timing code all equal those of the last request carried out is accepted with req_ready staying high. Neither word changes and no init starts.
- R12: init_start is a one-cycle pulse that comes after all word updates. From acceptance onward, req_ready stays low until init_done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Mode request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_timing | input | 4 | Timing-mode code, 0 legacy to 10 DDR with strobe |
| req_sdio | input | 1 | Card is an SDIO card |
| req_slow_pref | input | 1 | Slow-mode preference |
| req_hi_freq | input | 1 | Card clock is above 52 MHz |
| req_clk_code | input | CLK_W | Clock-setting identifier, used for duplicate detection |
| req_bus_width | input | BW_W | Bus-width code, used for duplicate detection |
| card_clk_en | output | 1 | Card clock enable |
| phy_func_ctrl | output | 32 | PHY function word: [15:8] DQ DDR, 16 command DDR, 4 async |
| phy_timing_adj | output | 32 | PHY timing word: 28 SDIO mode, 29 slow mode |
| init_start | output | 1 | One-cycle PHY init trigger |
| init_done | input | 1 | PHY init finished |

## Verification
Take the request accepted on clock edge k. Bit 28 is written at edge k+1 and bit 29 at edge k+2. On the full path, card_clk_en falls at k+3, the function word changes at k+4, the clock returns at k+5 and init_start is high in the cycle after k+5. The slow path raises init_start after edge k+2, and the legacy path raises it after edge k+1. The scoreboard therefore compares both words at the falling edge where init_start is first seen, since every write is complete by then. Between init pulses it records whether the clock was ever gated and checks that against the expected path. Duplicate requests are checked one falling edge after acceptance, then again a few cycles later to confirm that no init pulse appeared.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

  typedef enum logic [3:0] {
    TM_LEGACY = 4'd0,
    TM_MMC_HS = 4'd1,
    TM_SD_HS  = 4'd2,
    TM_SDR12  = 4'd3,
    TM_SDR25  = 4'd4,
    TM_SDR50  = 4'd5,
    TM_SDR104 = 4'd6,
    TM_DDR50  = 4'd7,
    TM_DDR52  = 4'd8,
    TM_HS200  = 4'd9,
    TM_HS400  = 4'd10
  } timing_e;

  localparam int REG_W       = 32;
  localparam int ASYNC_BIT   = 4;
  localparam int DQDDR_LSB   = 8;
  localparam int CMD_DDR_BIT = 16;
  localparam int SDIO_BIT    = 28;
  localparam int SLOW_BIT    = 29;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SDIO, ST_SLOW, ST_GATE, ST_FUNC, ST_UNGATE, ST_INIT, ST_WAIT
  } seq_e;

  typedef struct packed {
    logic hi;
    logic legacy;
    logic sdio;
    logic slow;
    logic dq_ddr;
    logic cmd_ddr;
    logic dq_async;
  } plan_t;

endpackage

// File: rtl/phy_cfg_decode.sv
module phy_cfg_decode
  import phy_cfg_pkg::*;
(
  input  logic [3:0] timing,
  input  logic       sdio,
  input  logic       slow_pref,
  input  logic       hi_freq,
  output plan_t      plan
);

  always_comb begin
    plan          = '0;
    plan.hi       = hi_freq;
    plan.sdio     = sdio;
    plan.legacy   = (timing == TM_LEGACY);
    plan.dq_async = 1'b1;
    unique case (timing_e'(timing))
      TM_LEGACY: plan.slow = slow_pref & ~hi_freq;
      TM_MMC_HS, TM_SD_HS, TM_SDR12, TM_SDR25:
        plan.slow = ~hi_freq & (sdio | slow_pref);
      default: plan.slow = 1'b0;
    endcase
    unique case (timing_e'(timing))
      TM_HS400: begin
        plan.dq_ddr   = 1'b1;
        plan.cmd_ddr  = 1'b1;
        plan.dq_async = 1'b0;
      end
      TM_DDR50, TM_DDR52: begin
        plan.dq_ddr  = 1'b1;
        plan.cmd_ddr = 1'b1;
      end
      default: begin
        plan.dq_ddr  = 1'b0;
        plan.cmd_ddr = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/phy_cfg_seq.sv
module phy_cfg_seq
  import phy_cfg_pkg::*;
#(
  parameter int CLK_W = 8,
  parameter int BW_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [3:0]       req_timing,
  input  logic [CLK_W-1:0] req_clk_code,
  input  logic [BW_W-1:0]  req_bus_width,
  input  plan_t            plan,
  input  logic             init_done,
  output logic             req_ready,
  output plan_t            plan_q,
  output logic             sdio_we,
  output logic             slow_we,
  output logic             gate,
  output logic             func_we,
  output logic             ungate,
  output logic             init_start
);

  seq_e             state_q, state_d;
  logic [CLK_W-1:0] prev_clk_q;
  logic [BW_W-1:0]  prev_bw_q;
  logic [3:0]       prev_tm_q;
  logic             prev_vld_q;
  logic             dup, accept, load_en;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign dup       = prev_vld_q && (req_clk_code == prev_clk_q) &&
                     (req_bus_width == prev_bw_q) && (req_timing == prev_tm_q);
  assign load_en   = accept & ~dup;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (load_en) state_d = plan.legacy ? ST_SLOW : ST_SDIO;
      ST_SDIO:   state_d = ST_SLOW;
      ST_SLOW:   state_d = (plan_q.slow | plan_q.legacy) ? ST_INIT : ST_GATE;
      ST_GATE:   state_d = ST_FUNC;
      ST_FUNC:   state_d = ST_UNGATE;
      ST_UNGATE: state_d = ST_INIT;
      ST_INIT:   state_d = ST_WAIT;
      ST_WAIT:   if (init_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      plan_q     <= '0;
      prev_clk_q <= '0;
      prev_bw_q  <= '0;
      prev_tm_q  <= '0;
      prev_vld_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_en) begin
        plan_q     <= plan;
        prev_clk_q <= req_clk_code;
        prev_bw_q  <= req_bus_width;
        prev_tm_q  <= req_timing;
        prev_vld_q <= 1'b1;
      end
    end
  end

  assign sdio_we    = (state_q == ST_SDIO);
  assign slow_we    = (state_q == ST_SLOW);
  assign gate       = (state_q == ST_GATE);
  assign func_we    = (state_q == ST_FUNC);
  assign ungate     = (state_q == ST_UNGATE);
  assign init_start = (state_q == ST_INIT);

  // R11
  dup_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && dup) |=> req_ready);

  // R12
  busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !init_done) |=> !req_ready);

  // R12
  init_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> !init_start);

endmodule

// File: rtl/phy_cfg_regs.sv
module phy_cfg_regs
  import phy_cfg_pkg::*;
#(
  parameter int DQ_LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdio_we,
  input  logic             slow_we,
  input  logic             gate,
  input  logic             func_we,
  input  logic             ungate,
  input  logic             sdio_val,
  input  logic             slow_val,
  input  logic             dq_ddr_val,
  input  logic             cmd_ddr_val,
  input  logic             async_val,
  output logic [REG_W-1:0] func_word,
  output logic [REG_W-1:0] timing_word,
  output logic             card_clk_en
);

  localparam logic [REG_W-1:0] FUNC_RST = REG_W'(1) << ASYNC_BIT;

  logic [REG_W-1:0] func_d, timing_d;
  logic             clk_en_d;

  always_comb begin
    func_d = func_word;
    if (func_we) begin
      func_d[DQDDR_LSB +: DQ_LANES] = {DQ_LANES{dq_ddr_val}};
      func_d[CMD_DDR_BIT]           = cmd_ddr_val;
      func_d[ASYNC_BIT]             = async_val;
    end
    timing_d = timing_word;
    if (sdio_we) timing_d[SDIO_BIT] = sdio_val;
    if (slow_we) timing_d[SLOW_BIT] = slow_val;
    clk_en_d = card_clk_en;
    if (gate)   clk_en_d = 1'b0;
    if (ungate) clk_en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_word   <= FUNC_RST;
      timing_word <= '0;
      card_clk_en <= 1'b1;
    end else begin
      func_word   <= func_d;
      timing_word <= timing_d;
      card_clk_en <= clk_en_d;
    end
  end

  // R5
  func_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(func_word) |-> (!card_clk_en && !$past(card_clk_en)));

endmodule

// File: rtl/phy_speed_cfg.sv
module phy_speed_cfg
  import phy_cfg_pkg::*;
#(
  parameter int CLK_W    = 8,
  parameter int BW_W     = 2,
  parameter int DQ_LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_timing,
  input  logic             req_sdio,
  input  logic             req_slow_pref,
  input  logic             req_hi_freq,
  input  logic [CLK_W-1:0] req_clk_code,
  input  logic [BW_W-1:0]  req_bus_width,
  output logic             card_clk_en,
  output logic [31:0]      phy_func_ctrl,
  output logic [31:0]      phy_timing_adj,
  output logic             init_start,
  input  logic             init_done
);

  plan_t plan, plan_q;
  logic  sdio_we, slow_we, gate, func_we, ungate;

  phy_cfg_decode u_decode (
    .timing    (req_timing),
    .sdio      (req_sdio),
    .slow_pref (req_slow_pref),
    .hi_freq   (req_hi_freq),
    .plan      (plan)
  );

  phy_cfg_seq #(.CLK_W(CLK_W), .BW_W(BW_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_timing    (req_timing),
    .req_clk_code  (req_clk_code),
    .req_bus_width (req_bus_width),
    .plan          (plan),
    .init_done     (init_done),
    .req_ready     (req_ready),
    .plan_q        (plan_q),
    .sdio_we       (sdio_we),
    .slow_we       (slow_we),
    .gate          (gate),
    .func_we       (func_we),
    .ungate        (ungate),
    .init_start    (init_start)
  );

  phy_cfg_regs #(.DQ_LANES(DQ_LANES)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .sdio_we     (sdio_we),
    .slow_we     (slow_we),
    .gate        (gate),
    .func_we     (func_we),
    .ungate      (ungate),
    .sdio_val    (plan_q.sdio),
    .slow_val    (plan_q.slow),
    .dq_ddr_val  (plan_q.dq_ddr),
    .cmd_ddr_val (plan_q.cmd_ddr),
    .async_val   (plan_q.dq_async),
    .func_word   (phy_func_ctrl),
    .timing_word (phy_timing_adj),
    .card_clk_en (card_clk_en)
  );

  // R6
  slow_needs_low_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_timing_adj[SLOW_BIT]) |-> !plan_q.hi);

  // R9
  no_gate_when_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_clk_en) |-> !plan_q.slow);

endmodule

// File: tb/phy_speed_cfg_test.sv
module phy_speed_cfg_test;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_LAT   = 6;
  localparam int WD_CYCLES  = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_sdio = 1'b0, req_slow_pref = 1'b0, req_hi_freq = 1'b0;
  logic [3:0] req_timing = '0;
  logic [7:0] req_clk_code = '0;
  logic [1:0] req_bus_width = '0;
  logic init_done = 1'b0;
  logic req_ready, card_clk_en, init_start;
  logic [31:0] phy_func_ctrl, phy_timing_adj;

  int n_cmp = 0, n_bad = 0, init_cnt = 0, exp_init = 0;
  bit finished = 0, saw_gate = 0;
  logic [31:0] m_func = 32'h10, m_tim = 32'h0;
  logic [31:0] q_func[$], q_tim[$];
  bit q_gate[$];
  string q_tag[$];

  phy_speed_cfg uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected words at each init pulse
  always @(negedge clk) if (rst_n) begin
    if (!card_clk_en) saw_gate = 1;
    if (init_start) begin
      init_cnt++;
      if (q_func.size() == 0) chk(0, "R11", "unexpected init", 1, 0);
      else begin
        automatic logic [31:0] ef = q_func.pop_front();
        automatic logic [31:0] et = q_tim.pop_front();
        automatic bit eg = q_gate.pop_front();
        automatic string tg = q_tag.pop_front();
        chk(phy_func_ctrl == ef, tg, "func word", phy_func_ctrl, ef);
        chk(phy_timing_adj == et, tg, "timing word", phy_timing_adj, et);
        chk(saw_gate == eg, tg, "clock gated (R5)", 32'(saw_gate), 32'(eg));
        chk(card_clk_en == 1'b1, tg, "clock back on at init (R5)", 32'(card_clk_en), 1);
      end
      saw_gate = 0;
    end
  end

  // init responder
  initial forever begin
    @(negedge clk);
    if (rst_n && init_start) begin
      repeat (INIT_LAT) @(negedge clk);
      chk(req_ready == 1'b0, "R12", "ready low before done", 32'(req_ready), 0);
      init_done = 1'b1;
      @(negedge clk);
      init_done = 1'b0;
    end
  end

  task automatic send(input logic [3:0] tm, input bit sdio, input bit pref, input bit hi,
                      input logic [7:0] cc, input logic [1:0] bw, input bit dup, input string tag);
    bit slow, legacy;
    legacy = (tm == 4'd0);
    if (legacy) slow = pref && !hi;
    else if (tm >= 4'd1 && tm <= 4'd4) slow = !hi && (sdio || pref);
    else slow = 0;
    if (!dup) begin
      if (!legacy) m_tim[28] = sdio;
      m_tim[29] = slow;
      if (!legacy && !slow) begin
        if (tm == 4'd10) m_func = 32'h0001_FF00;
        else if (tm == 4'd7 || tm == 4'd8) m_func = 32'h0001_FF10;
        else m_func = 32'h0000_0010;
      end
      q_func.push_back(m_func); q_tim.push_back(m_tim);
      q_gate.push_back(!legacy && !slow); q_tag.push_back(tag);
      exp_init++;
    end
    @(negedge clk);
    req_timing = tm; req_sdio = sdio; req_slow_pref = pref; req_hi_freq = hi;
    req_clk_code = cc; req_bus_width = bw; req_valid = 1'b1;
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (dup) begin
      chk(req_ready == 1'b1, "R11", "ready after duplicate", 32'(req_ready), 1);
      chk(phy_func_ctrl == m_func, "R11", "func unchanged", phy_func_ctrl, m_func);
      chk(phy_timing_adj == m_tim, "R11", "timing unchanged", phy_timing_adj, m_tim);
      repeat (8) @(negedge clk);
      chk(init_cnt == exp_init, "R11", "no init for duplicate", 32'(init_cnt), 32'(exp_init));
    end else begin
      chk(req_ready == 1'b0, "R12", "ready drops on accept", 32'(req_ready), 0);
      while (!req_ready) @(negedge clk);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R12 watchdog: actual hung expected idle");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 1);
    chk(card_clk_en == 1'b1, "R1", "reset clk en", 32'(card_clk_en), 1);
    chk(init_start == 1'b0, "R1", "reset init", 32'(init_start), 0);
    chk(phy_func_ctrl == 32'h10, "R1", "reset func", phy_func_ctrl, 32'h10);
    chk(phy_timing_adj == 32'h0, "R1", "reset timing", phy_timing_adj, 0);

    send(4'd10, 0, 0, 1, 8'd200, 2'd2, 0, "R2");
    send(4'd10, 1, 1, 1, 8'd200, 2'd2, 1, "R11");
    send(4'd8,  0, 0, 0, 8'd52,  2'd2, 0, "R3");
    send(4'd6,  0, 0, 1, 8'd200, 2'd2, 0, "R4");
    send(4'd1,  0, 0, 0, 8'd26,  2'd2, 0, "R7");
    send(4'd7,  0, 0, 0, 8'd50,  2'd1, 0, "R3");
    send(4'd2,  1, 0, 0, 8'd50,  2'd1, 0, "R9");
    send(4'd4,  1, 1, 1, 8'd60,  2'd1, 0, "R6");
    send(4'd3,  0, 1, 0, 8'd25,  2'd1, 0, "R7");
    send(4'd10, 1, 0, 1, 8'd200, 2'd2, 0, "R10");
    send(4'd0,  0, 1, 0, 8'd1,   2'd0, 0, "R8");
    send(4'd0,  0, 1, 1, 8'd2,   2'd0, 0, "R8");
    send(4'd0,  1, 0, 0, 8'd2,   2'd0, 1, "R11");

    repeat (5) @(negedge clk);
    chk(init_cnt == exp_init, "R12", "init count", 32'(init_cnt), 32'(exp_init));
    chk(q_func.size() == 0, "R12", "pending items", 32'(q_func.size()), 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule